// File: doc/BRIEF.md
# Toggle-Handshake Word Transfer Across Clock Domains

This block carries one multi-bit word at a time from a source clock domain into a destination clock domain. The two clocks are unrelated. On the source side a word is taken with a valid/ready handshake and parked in a holding register. A single request bit then changes state once to announce it. The destination passes that bit through a chain of flip-flops. It compares the last two flops of the chain to produce a capture strobe that is exactly one cycle wide. It then registers the parked word and shows it for one cycle with a valid flag.

The level at the end of the destination chain is fed back to the source and resynchronized there. It serves as the acknowledge. The source stays busy, with ready low, until the returned level matches the request bit. Because of this, only one word is ever in flight, and the parked word is guaranteed stable whenever the destination samples it. Each domain has its own active-low asynchronous reset.

Top module: `tgl_cdc_xfer`

## Requirements
- R1: A word is accepted on a source clock edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 on the cycle that follows an acceptance.
- R2: While `src_ready` is 0, the parked word does not change. Words offered with `src_valid` high during that time are not taken and never reach the destination.
- R3: The request bit changes state exactly once for each accepted word. It never changes on a cycle without an acceptance.
- R4: The destination synchronizer has three flops clocked by `dst_clk`. The capture strobe is the XOR of its second and third flops. It is high for one destination cycle per request change, whether that change is 0-to-1 or 1-to-0.
- R5: `dst_valid` is high for exactly one destination cycle, the cycle after the capture strobe. `dst_data` carries the captured word during that cycle.
- R6: Every accepted word appears at `dst_data` exactly once and in acceptance order. This holds for a source clock faster than the destination clock and for one slower than it.
- R7: After reset, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0. All synchronizer flops and the request bit are 0, so no strobe comes out of reset.
- R8: After an acceptance, `src_ready` returns to 1 once the third destination flop has gone back through the two-flop source synchronizer and equals the request bit. This takes a bounded number of source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain active-low asynchronous reset |
| src_valid | input | 1 | A word is offered on `src_data` |
| src_ready | output | 1 | The block can take a word this cycle |
| src_data | input | W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain active-low asynchronous reset |
| dst_valid | output | 1 | One-cycle flag marking a delivered word |
| dst_data | output | W | Delivered word, meaningful while `dst_valid` is 1 |

## Verification
`src_ready` drops at the first source edge after an acceptance. The bench checks this at the falling edge that follows, and at that same edge it swaps in a junk word to test R2. The flipped request reaches the third destination flop on the third `dst_clk` edge that samples it, give or take one edge for metastability. `dst_valid` is registered one edge after the strobe. The exact destination cycle is therefore uncertain, so the bench pairs each delivery with a queue of accepted words instead of a fixed cycle count. It samples `dst_valid` at every falling edge of `dst_clk` to confirm the one-cycle width. The acknowledge needs two more source edges after the third destination flop changes. Each wait for ready is bounded at 64 source cycles.

// File: rtl/tgl_cdc_pkg.sv
`timescale 1ns/1ps
package tgl_cdc_pkg;

  // Change detector between two adjacent synchronizer flops.
  function automatic logic tgl_changed(input logic newer, input logic older);
    return newer ^ older;
  endfunction

  // The source is idle once the returned level caught up with the request.
  function automatic logic ack_caught_up(input logic ack_level, input logic req_level);
    return ack_level == req_level;
  endfunction

endpackage

// File: rtl/tgl_src_side.sv
`timescale 1ns/1ps
module tgl_src_side #(
  parameter int W          = 32,
  parameter int ACK_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         ack_level,
  output logic         req_tgl,
  output logic [W-1:0] hold_word
);
  import tgl_cdc_pkg::*;

  logic [ACK_STAGES-1:0] ack_pipe;
  logic                  take;

  assign in_ready = ack_caught_up(ack_pipe[ACK_STAGES-1], req_tgl);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_pipe <= '0;
    end else begin
      ack_pipe <= {ack_pipe[ACK_STAGES-2:0], ack_level};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      hold_word <= '0;
    end else if (take) begin
      req_tgl   <= ~req_tgl;
      hold_word <= in_data;
    end
  end

endmodule

// File: rtl/tgl_dst_sync.sv
`timescale 1ns/1ps
module tgl_dst_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic cap_strobe,
  output logic ret_level
);
  import tgl_cdc_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe <= {pipe[STAGES-2:0], req_async};
    end
  end

  assign cap_strobe = tgl_changed(pipe[LAST-1], pipe[LAST]);
  assign ret_level  = pipe[LAST];

endmodule

// File: rtl/tgl_dst_capture.sv
`timescale 1ns/1ps
module tgl_dst_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_strobe,
  input  logic [W-1:0] word_in,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= cap_strobe;
      if (cap_strobe) begin
        out_data <= word_in;
      end
    end
  end

endmodule

// File: rtl/tgl_cdc_xfer.sv
`timescale 1ns/1ps
module tgl_cdc_xfer #(
  parameter int W = 32
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_valid,
  output logic         src_ready,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);

  localparam int DST_STAGES = 3;
  localparam int ACK_STAGES = 2;

  logic         req_tgl;
  logic [W-1:0] hold_word;
  logic         ret_level;
  logic         cap_strobe;

  tgl_src_side #(.W(W), .ACK_STAGES(ACK_STAGES)) u_src (
    .clk       (src_clk),
    .rst_n     (src_rst_n),
    .in_valid  (src_valid),
    .in_ready  (src_ready),
    .in_data   (src_data),
    .ack_level (ret_level),
    .req_tgl   (req_tgl),
    .hold_word (hold_word)
  );

  tgl_dst_sync #(.STAGES(DST_STAGES)) u_sync (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n),
    .req_async  (req_tgl),
    .cap_strobe (cap_strobe),
    .ret_level  (ret_level)
  );

  tgl_dst_capture #(.W(W)) u_cap (
    .clk        (dst_clk),
    .rst_n      (dst_rst_n),
    .cap_strobe (cap_strobe),
    .word_in    (hold_word),
    .out_valid  (dst_valid),
    .out_data   (dst_data)
  );

endmodule

// File: rtl/tgl_cdc_xfer_chk.sv
`timescale 1ns/1ps
module tgl_cdc_xfer_chk #(
  parameter int W = 32
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         src_valid,
  input logic         src_ready,
  input logic         req_tgl,
  input logic [W-1:0] hold_word,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic         cap_strobe,
  input logic         dst_valid
);

  a_r1_busy_after_take: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && src_ready) |=> !src_ready);

  a_r2_word_held: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_ready |=> $stable(hold_word));

  a_r3_flip_on_take: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && src_ready) |=> (req_tgl != $past(req_tgl)));

  a_r3_no_flip_idle: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !(src_valid && src_ready) |=> $stable(req_tgl));

  a_r4_strobe_one_cycle: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    cap_strobe |=> !cap_strobe);

  a_r5_valid_after_strobe: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    cap_strobe |=> dst_valid);

  a_r5_valid_has_cause: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |-> $past(cap_strobe));

endmodule

bind tgl_cdc_xfer tgl_cdc_xfer_chk #(.W(W)) u_chk (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .req_tgl    (req_tgl),
  .hold_word  (hold_word),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .cap_strobe (cap_strobe),
  .dst_valid  (dst_valid)
);

// File: tb/tgl_cdc_xfer_bench.sv
`timescale 1ns/1ps
module tgl_cdc_xfer_bench;

  localparam int W            = 32;
  localparam int SRC_PER_FAST = 10;
  localparam int DST_PER_SLOW = 38;
  localparam int SRC_PER_SLOW = 30;
  localparam int DST_PER_FAST = 6;
  localparam int READY_LIMIT  = 64;

  int src_half = SRC_PER_FAST / 2;
  int dst_half = DST_PER_SLOW / 2;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         src_rst_n = 1'b0;
  logic         dst_rst_n = 1'b0;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_ready;
  logic         dst_valid;
  logic [W-1:0] dst_data;

  int checks = 0;
  int failures = 0;
  int sent = 0;
  int recvd = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic prev_valid = 1'b0;

  tgl_cdc_xfer #(.W(W)) u_tgl_cdc_xfer (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_valid (dst_valid),
    .dst_data  (dst_data)
  );

  initial forever #(src_half) src_clk = ~src_clk;
  initial forever #(dst_half) dst_clk = ~dst_clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Destination monitor: in-order delivery (R6) and one-cycle valid (R5).
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (dst_valid) begin
        check(!prev_valid, "R5 valid single cycle", {31'b0, prev_valid}, '0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected word", dst_data, '0);
        end else begin
          check(dst_data == exp_q[0], "R6 word order", dst_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
        recvd++;
      end
      prev_valid = dst_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic t_reset();
    src_valid = 1'b0;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    exp_q.delete();
    sent = 0;
    recvd = 0;
    repeat (4) @(negedge src_clk);
    repeat (4) @(negedge dst_clk);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    check(src_ready == 1'b1, "R7 ready after reset", {31'b0, src_ready}, 1);
    repeat (5) begin
      @(negedge dst_clk);
      check(dst_valid == 1'b0, "R7 no valid out of reset", {31'b0, dst_valid}, 0);
      check(dst_data == '0, "R7 data cleared", dst_data, '0);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit junk_while_busy);
    int n = 0;
    @(negedge src_clk);
    src_valid = 1'b1;
    src_data  = w;
    while (!src_ready && n < READY_LIMIT) begin
      @(negedge src_clk);
      n++;
    end
    check(src_ready == 1'b1, "R8 ready returns in bound", {31'b0, src_ready}, 1);
    if (!src_ready) begin
      src_valid = 1'b0;
      return;
    end
    exp_q.push_back(w);
    sent++;
    @(negedge src_clk);
    check(src_ready == 1'b0, "R1 busy after accept", {31'b0, src_ready}, 0);
    if (junk_while_busy) begin
      src_data = ~w;
      n = 0;
      while (!src_ready && n < READY_LIMIT) begin
        @(negedge src_clk);
        n++;
      end
    end
    src_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(negedge dst_clk);
      n++;
    end
    repeat (8) @(negedge dst_clk);
    check(exp_q.size() == 0, {"R6 all delivered ", tag}, exp_q.size(), 0);
    check(recvd == sent, {"R4 one strobe per toggle ", tag}, recvd, sent);
  endtask

  task automatic t_fast_to_slow();
    src_half = SRC_PER_FAST / 2;
    dst_half = DST_PER_SLOW / 2;
    t_reset();
    for (int i = 0; i < 21; i++) send_word($urandom(), i[0]);
    drain("fast-to-slow");
  endtask

  task automatic t_slow_to_fast();
    src_half = SRC_PER_SLOW / 2;
    dst_half = DST_PER_FAST / 2;
    t_reset();
    for (int i = 0; i < 20; i++) send_word($urandom(), !i[0]);
    drain("slow-to-fast");
  endtask

  task automatic t_busy_junk();
    // R2: junk offered while busy must never show up at the destination.
    src_half = SRC_PER_FAST / 2;
    dst_half = DST_PER_FAST / 2 + 4;
    t_reset();
    send_word(32'hA5A5_0001, 1'b1);
    send_word(32'h0000_0000, 1'b1);
    send_word(32'hFFFF_FFFF, 1'b1);
    drain("R2 busy junk");
  endtask

  initial begin
    t_fast_to_slow();
    t_slow_to_fast();
    t_busy_junk();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule